// File: doc/BRIEF.md
# Single-Bus Multicycle Control Sequencer

This block is the control unit of a 32-bit processor whose datapath shares one bus among all of its registers. A three-bit step counter walks through timing steps T0 to T7. In each step a combinational decoder drives one-hot control outputs:

- which register drives the bus;
- which registers latch at the end of the cycle;
- the ALU function;
- memory read and write requests;
- a few side controls for the shift counter, the C register and the A register.

The datapath registers, the ALU and memory sit outside the block. The sequencer sees them only through four inputs: the opcode and rb-is-zero test taken from the instruction register, the latched branch condition, and the zero test of the shift counter. Every instruction starts with a common three-step fetch. The instruction's own steps follow, and the counter then returns to T0. Memory steps stall until the memory reports completion. The shift step repeats, one bit per cycle, until the shift counter reaches zero.

A start pulse sets a run flag and the stop instruction clears it. T0 only begins a fetch while the flag is set.

Top module: `bus_seq_top`

## Requirements
- R1: An asynchronous active-low reset forces the step counter to 0 and the run flag to 0, with every control output inactive.
- R2: At most one bus driver is selected in any cycle. The bus_src bits are: 0 PC, 1 MD, 2 C, 3 R[ra], 4 R[rb], 5 R[rc], 6 sign-extended immediate.
- R3: Fetch runs in three steps, with these encodings:
  - reg_ld bits: 0 MA, 1 PC, 2 MD from bus, 3 IR, 4 A, 5 C, 6 R[ra], 7 CON.
  - alu_op codes: 0 none, 1 plus four, 2 add, 3 pass.
  - Step 0 (only while running): PC drives the bus, MA and C load, and alu_op is 1.
  - Step 1: mem_rd is high. In its completion cycle md_mem_ld is set, C drives the bus and PC loads.
  - Step 2: MD drives the bus into IR.
  - With the run flag clear, step 0 drives nothing.
- R4: A memory step (fetch step 1, load step 6, store step 7) holds the step counter and its request for as long as mem_done is low. MD loads from memory only in the cycle where mem_done is high.
- R5: add (opcode 12) and addi (opcode 13) run as follows. Step 3: R[rb] into A. Step 4: R[rc] (add) or the immediate (addi) is added into C. Step 5: C into R[ra].
- R6: ld (opcode 1) runs as follows:
  - Step 3: A loads zero (a_zero, with no bus driver) when rb_is_zero is high, and loads R[rb] otherwise.
  - Step 4: the immediate is added into C.
  - Step 5: C into MA.
  - Step 6: memory read into MD.
  - Step 7: MD into R[ra].
- R7: st (opcode 3) repeats the ld steps 3 to 5. Step 6: R[ra] into MD over the bus. Step 7: mem_wr, held until completion. mem_rd and mem_wr are never high together.
- R8: br (opcode 8) runs as follows. Step 3: R[rc] drives the bus and CON loads. Step 4: R[rb] loads PC only when con_flag is high; otherwise the step drives nothing.
- R9: shr (opcode 26) runs as follows:
  - Step 3: n_ld_ir.
  - Step 4: R[rc] onto the bus with n_ld_bus, only if n_is_zero.
  - Step 5: R[rb] passed into C.
  - Step 6: c_shr and n_dec each cycle while n_is_zero is low, holding the step; it advances with no controls once n_is_zero is high.
  - Step 7: C into R[ra].
- R10: A start pulse sets the run flag from the next cycle. stop (opcode 31) spends one quiet step 3 and clears the run flag, so the next step 0 is idle. nop (opcode 0) spends one quiet step 3.
- R11: After the last step of any instruction, the next cycle is step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sets the run flag |
| ir_opcode | input | OP_W | Opcode field of the instruction register |
| rb_is_zero | input | 1 | The rb field of the instruction register is zero |
| con_flag | input | 1 | Latched branch condition |
| n_is_zero | input | 1 | Shift counter equals zero |
| mem_done | input | 1 | Memory completion |
| bus_src | output | 7 | One-hot bus driver select |
| reg_ld | output | 8 | Register load enables |
| alu_op | output | 2 | ALU function |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| md_mem_ld | output | 1 | MD loads from memory data |
| a_zero | output | 1 | A loads zero |
| n_ld_ir | output | 1 | Shift counter loads IR bits 4..0 |
| n_ld_bus | output | 1 | Shift counter loads bus bits 4..0 |
| n_dec | output | 1 | Shift counter decrements |
| c_shr | output | 1 | C shifts right one bit |
| running | output | 1 | Run flag |
| step | output | 3 | Current timing step |

## Verification
The bench builds the sequencer with its default parameters: a five-bit opcode and the opcode values listed above. This lets every path be walked step by step:

- all eight steps, on both arms of the rb-is-zero test and the branch condition;
- memory stalls of zero to two cycles in fetch, load and store;
- a shift loop of three passes, and one with no passes;
- the idle state after stop, followed by a restart.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int STEP_W   = 3;
  localparam int NSRC     = 7;
  localparam int NLD      = 8;
  localparam int ALU_W    = 2;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'((1 << STEP_W) - 1);

  localparam int SRC_PC  = 0;
  localparam int SRC_MD  = 1;
  localparam int SRC_C   = 2;
  localparam int SRC_RA  = 3;
  localparam int SRC_RB  = 4;
  localparam int SRC_RC  = 5;
  localparam int SRC_IMM = 6;

  localparam int LD_MA  = 0;
  localparam int LD_PC  = 1;
  localparam int LD_MD  = 2;
  localparam int LD_IR  = 3;
  localparam int LD_A   = 4;
  localparam int LD_C   = 5;
  localparam int LD_RA  = 6;
  localparam int LD_CON = 7;

  typedef enum logic [ALU_W-1:0] {
    ALU_NONE = 2'd0,
    ALU_INC4 = 2'd1,
    ALU_ADD  = 2'd2,
    ALU_PASS = 2'd3
  } alu_op_e;
endpackage

// File: rtl/seq_run_flag.sv
module seq_run_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop_hit,
  output logic run
);
  logic run_d;

  always_comb begin
    run_d = run;
    if (start)         run_d = 1'b1;
    else if (stop_hit) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= run_d;
  end

  // R10
  start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run);
endmodule

// File: rtl/seq_step_ctr.sv
module seq_step_ctr
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              hold,
  input  logic              last,
  output logic [STEP_W-1:0] step
);
  logic [STEP_W-1:0] step_d;
  logic              step_en;

  always_comb begin
    step_en = !(step == '0 && !run) && !hold;
    step_d  = last ? '0 : step + STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= '0;
    else if (step_en) step <= step_d;
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> step == $past(step));

  // R11
  wrap_to_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == LAST_STEP && !hold) |=> step == '0);
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int OP_W     = 5,
  parameter int OPC_NOP  = 0,
  parameter int OPC_LD   = 1,
  parameter int OPC_ST   = 3,
  parameter int OPC_BR   = 8,
  parameter int OPC_ADD  = 12,
  parameter int OPC_ADDI = 13,
  parameter int OPC_SHR  = 26,
  parameter int OPC_STOP = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic              run,
  input  logic [OP_W-1:0]   opcode,
  input  logic              rb_is_zero,
  input  logic              con_flag,
  input  logic              n_is_zero,
  input  logic              mem_done,
  output logic [NSRC-1:0]   bus_src,
  output logic [NLD-1:0]    reg_ld,
  output alu_op_e           alu_op,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              md_mem_ld,
  output logic              a_zero,
  output logic              n_ld_ir,
  output logic              n_ld_bus,
  output logic              n_dec,
  output logic              c_shr,
  output logic              hold,
  output logic              last,
  output logic              stop_hit
);
  localparam logic [OP_W-1:0] K_NOP  = OP_W'(OPC_NOP);
  localparam logic [OP_W-1:0] K_LD   = OP_W'(OPC_LD);
  localparam logic [OP_W-1:0] K_ST   = OP_W'(OPC_ST);
  localparam logic [OP_W-1:0] K_BR   = OP_W'(OPC_BR);
  localparam logic [OP_W-1:0] K_ADD  = OP_W'(OPC_ADD);
  localparam logic [OP_W-1:0] K_ADDI = OP_W'(OPC_ADDI);
  localparam logic [OP_W-1:0] K_SHR  = OP_W'(OPC_SHR);
  localparam logic [OP_W-1:0] K_STOP = OP_W'(OPC_STOP);

  always_comb begin
    bus_src = '0; reg_ld = '0; alu_op = ALU_NONE;
    mem_rd = 1'b0; mem_wr = 1'b0; md_mem_ld = 1'b0; a_zero = 1'b0;
    n_ld_ir = 1'b0; n_ld_bus = 1'b0; n_dec = 1'b0; c_shr = 1'b0;
    hold = 1'b0; last = 1'b0; stop_hit = 1'b0;
    case (step)
      3'd0: if (run) begin
        bus_src[SRC_PC] = 1'b1; reg_ld[LD_MA] = 1'b1; reg_ld[LD_C] = 1'b1;
        alu_op = ALU_INC4;
      end
      3'd1: begin
        mem_rd = 1'b1;
        if (mem_done) begin
          md_mem_ld = 1'b1; bus_src[SRC_C] = 1'b1; reg_ld[LD_PC] = 1'b1;
        end else hold = 1'b1;
      end
      3'd2: begin bus_src[SRC_MD] = 1'b1; reg_ld[LD_IR] = 1'b1; end
      3'd3: case (opcode)
        K_ADD, K_ADDI: begin bus_src[SRC_RB] = 1'b1; reg_ld[LD_A] = 1'b1; end
        K_LD, K_ST: begin
          reg_ld[LD_A] = 1'b1;
          if (rb_is_zero) a_zero = 1'b1;
          else            bus_src[SRC_RB] = 1'b1;
        end
        K_BR:   begin bus_src[SRC_RC] = 1'b1; reg_ld[LD_CON] = 1'b1; end
        K_SHR:  n_ld_ir = 1'b1;
        K_STOP: begin stop_hit = 1'b1; last = 1'b1; end
        K_NOP:  last = 1'b1;
        default: last = 1'b1;
      endcase
      3'd4: case (opcode)
        K_ADD: begin bus_src[SRC_RC] = 1'b1; reg_ld[LD_C] = 1'b1; alu_op = ALU_ADD; end
        K_ADDI, K_LD, K_ST: begin
          bus_src[SRC_IMM] = 1'b1; reg_ld[LD_C] = 1'b1; alu_op = ALU_ADD;
        end
        K_BR: begin
          last = 1'b1;
          if (con_flag) begin bus_src[SRC_RB] = 1'b1; reg_ld[LD_PC] = 1'b1; end
        end
        K_SHR: if (n_is_zero) begin bus_src[SRC_RC] = 1'b1; n_ld_bus = 1'b1; end
        default: last = 1'b1;
      endcase
      3'd5: case (opcode)
        K_ADD, K_ADDI: begin bus_src[SRC_C] = 1'b1; reg_ld[LD_RA] = 1'b1; last = 1'b1; end
        K_LD, K_ST:    begin bus_src[SRC_C] = 1'b1; reg_ld[LD_MA] = 1'b1; end
        K_SHR: begin bus_src[SRC_RB] = 1'b1; reg_ld[LD_C] = 1'b1; alu_op = ALU_PASS; end
        default: last = 1'b1;
      endcase
      3'd6: case (opcode)
        K_LD: begin
          mem_rd = 1'b1;
          if (mem_done) md_mem_ld = 1'b1;
          else          hold = 1'b1;
        end
        K_ST: begin bus_src[SRC_RA] = 1'b1; reg_ld[LD_MD] = 1'b1; end
        K_SHR: if (!n_is_zero) begin c_shr = 1'b1; n_dec = 1'b1; hold = 1'b1; end
        default: last = 1'b1;
      endcase
      default: begin
        last = 1'b1;
        case (opcode)
          K_LD:  begin bus_src[SRC_MD] = 1'b1; reg_ld[LD_RA] = 1'b1; end
          K_ST:  begin mem_wr = 1'b1; hold = !mem_done; end
          K_SHR: begin bus_src[SRC_C] = 1'b1; reg_ld[LD_RA] = 1'b1; end
          default: ;
        endcase
      end
    endcase
  end

  // R2
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_src));

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0 && !run) |-> (bus_src == '0 && reg_ld == '0 && !mem_rd));

  // R4
  md_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    md_mem_ld |-> mem_done);
endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import seq_pkg::*;
#(
  parameter int OP_W     = 5,
  parameter int OPC_NOP  = 0,
  parameter int OPC_LD   = 1,
  parameter int OPC_ST   = 3,
  parameter int OPC_BR   = 8,
  parameter int OPC_ADD  = 12,
  parameter int OPC_ADDI = 13,
  parameter int OPC_SHR  = 26,
  parameter int OPC_STOP = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   ir_opcode,
  input  logic              rb_is_zero,
  input  logic              con_flag,
  input  logic              n_is_zero,
  input  logic              mem_done,
  output logic [NSRC-1:0]   bus_src,
  output logic [NLD-1:0]    reg_ld,
  output logic [ALU_W-1:0]  alu_op,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              md_mem_ld,
  output logic              a_zero,
  output logic              n_ld_ir,
  output logic              n_ld_bus,
  output logic              n_dec,
  output logic              c_shr,
  output logic              running,
  output logic [STEP_W-1:0] step
);
  logic    hold, last, stop_hit, run;
  alu_op_e alu_e;

  seq_run_flag u_run (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_hit(stop_hit), .run(run)
  );

  seq_step_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold), .last(last), .step(step)
  );

  seq_decode #(
    .OP_W(OP_W), .OPC_NOP(OPC_NOP), .OPC_LD(OPC_LD), .OPC_ST(OPC_ST),
    .OPC_BR(OPC_BR), .OPC_ADD(OPC_ADD), .OPC_ADDI(OPC_ADDI),
    .OPC_SHR(OPC_SHR), .OPC_STOP(OPC_STOP)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .step(step), .run(run), .opcode(ir_opcode),
    .rb_is_zero(rb_is_zero), .con_flag(con_flag), .n_is_zero(n_is_zero),
    .mem_done(mem_done), .bus_src(bus_src), .reg_ld(reg_ld), .alu_op(alu_e),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .md_mem_ld(md_mem_ld), .a_zero(a_zero),
    .n_ld_ir(n_ld_ir), .n_ld_bus(n_ld_bus), .n_dec(n_dec), .c_shr(c_shr),
    .hold(hold), .last(last), .stop_hit(stop_hit)
  );

  assign alu_op  = alu_e;
  assign running = run;
endmodule

// File: tb/bus_seq_top_bench.sv
module bus_seq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n, start, rb_is_zero, con_flag, n_is_zero, mem_done;
  logic [4:0] ir_opcode;
  logic [6:0] bus_src;
  logic [7:0] reg_ld;
  logic [1:0] alu_op;
  logic       mem_rd, mem_wr, md_mem_ld, a_zero, n_ld_ir, n_ld_bus, n_dec, c_shr, running;
  logic [2:0] step;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  localparam logic [6:0] S_PC = 7'd1, S_MD = 7'd2, S_C = 7'd4, S_RA = 7'd8,
                         S_RB = 7'd16, S_RC = 7'd32, S_IM = 7'd64;
  localparam logic [7:0] L_MA = 8'd1, L_PC = 8'd2, L_MD = 8'd4, L_IR = 8'd8,
                         L_A = 8'd16, L_C = 8'd32, L_RA = 8'd64, L_CON = 8'd128;
  localparam logic [1:0] A_NO = 2'd0, A_INC = 2'd1, A_ADD = 2'd2, A_PAS = 2'd3;
  localparam logic [7:0] M_RD = 8'h80, M_WR = 8'h40, M_MDM = 8'h20, M_AZ = 8'h10,
                         M_NIR = 8'h08, M_NBUS = 8'h04, M_NDEC = 8'h02, M_SHR = 8'h01;

  always #10 clk = ~clk;

  bus_seq_top u_bus_seq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .ir_opcode(ir_opcode),
    .rb_is_zero(rb_is_zero), .con_flag(con_flag), .n_is_zero(n_is_zero),
    .mem_done(mem_done), .bus_src(bus_src), .reg_ld(reg_ld), .alu_op(alu_op),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .md_mem_ld(md_mem_ld), .a_zero(a_zero),
    .n_ld_ir(n_ld_ir), .n_ld_bus(n_ld_bus), .n_dec(n_dec), .c_shr(c_shr),
    .running(running), .step(step)
  );

  task automatic chk(input string req, input logic [6:0] es, input logic [7:0] el,
                     input logic [1:0] ea, input logic [7:0] em,
                     input logic [2:0] est, input logic erun);
    logic [7:0] misc;
    misc = {mem_rd, mem_wr, md_mem_ld, a_zero, n_ld_ir, n_ld_bus, n_dec, c_shr};
    n_chk++;
    if ({bus_src, reg_ld, alu_op, misc, step, running} !== {es, el, ea, em, est, erun}) begin
      n_bad++;
      $display("FAIL %s: src=%b ld=%b alu=%0d misc=%b step=%0d run=%b expected src=%b ld=%b alu=%0d misc=%b step=%0d run=%b",
               req, bus_src, reg_ld, alu_op, misc, step, running, es, el, ea, em, est, erun);
    end
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  task automatic fetch(input logic [4:0] op, input int waits);
    adv(); start = 1'b0; mem_done = 1'b0; #1;
    chk("R3/R11 T0", S_PC, L_MA | L_C, A_INC, 8'h00, 3'd0, 1'b1);
    for (int i = 0; i < waits; i++) begin
      adv(); mem_done = 1'b0; #1;
      chk("R4 fetch stall", 7'd0, 8'd0, A_NO, M_RD, 3'd1, 1'b1);
    end
    adv(); mem_done = 1'b1; #1;
    chk("R3 T1", S_C, L_PC, A_NO, M_RD | M_MDM, 3'd1, 1'b1);
    adv(); mem_done = 1'b0; ir_opcode = op; #1;
    chk("R3 T2", S_MD, L_IR, A_NO, 8'h00, 3'd2, 1'b1);
  endtask

  task automatic t_add();
    fetch(5'd12, 2);
    adv(); #1; chk("R5 add T3", S_RB, L_A, A_NO, 8'h00, 3'd3, 1'b1);
    adv(); #1; chk("R5 add T4", S_RC, L_C, A_ADD, 8'h00, 3'd4, 1'b1);
    adv(); #1; chk("R5 add T5", S_C, L_RA, A_NO, 8'h00, 3'd5, 1'b1);
  endtask

  task automatic t_addi();
    fetch(5'd13, 0);
    adv(); #1; chk("R5 addi T3", S_RB, L_A, A_NO, 8'h00, 3'd3, 1'b1);
    adv(); #1; chk("R5 addi T4", S_IM, L_C, A_ADD, 8'h00, 3'd4, 1'b1);
    adv(); #1; chk("R5 addi T5", S_C, L_RA, A_NO, 8'h00, 3'd5, 1'b1);
  endtask

  task automatic t_ld(input logic rbz, input int waits);
    fetch(5'd1, 0);
    adv(); rb_is_zero = rbz; #1;
    if (rbz) chk("R6 ld T3 zero", 7'd0, L_A, A_NO, M_AZ, 3'd3, 1'b1);
    else     chk("R6 ld T3 reg", S_RB, L_A, A_NO, 8'h00, 3'd3, 1'b1);
    adv(); #1; chk("R6 ld T4", S_IM, L_C, A_ADD, 8'h00, 3'd4, 1'b1);
    adv(); #1; chk("R6 ld T5", S_C, L_MA, A_NO, 8'h00, 3'd5, 1'b1);
    for (int i = 0; i < waits; i++) begin
      adv(); mem_done = 1'b0; #1;
      chk("R4 ld stall", 7'd0, 8'd0, A_NO, M_RD, 3'd6, 1'b1);
    end
    adv(); mem_done = 1'b1; #1;
    chk("R6 ld T6", 7'd0, 8'd0, A_NO, M_RD | M_MDM, 3'd6, 1'b1);
    adv(); mem_done = 1'b0; #1;
    chk("R6 ld T7", S_MD, L_RA, A_NO, 8'h00, 3'd7, 1'b1);
  endtask

  task automatic t_st(input int waits);
    fetch(5'd3, 0);
    adv(); rb_is_zero = 1'b0; #1; chk("R7 st T3", S_RB, L_A, A_NO, 8'h00, 3'd3, 1'b1);
    adv(); #1; chk("R7 st T4", S_IM, L_C, A_ADD, 8'h00, 3'd4, 1'b1);
    adv(); #1; chk("R7 st T5", S_C, L_MA, A_NO, 8'h00, 3'd5, 1'b1);
    adv(); #1; chk("R7 st T6", S_RA, L_MD, A_NO, 8'h00, 3'd6, 1'b1);
    for (int i = 0; i < waits; i++) begin
      adv(); mem_done = 1'b0; #1;
      chk("R4 st stall", 7'd0, 8'd0, A_NO, M_WR, 3'd7, 1'b1);
    end
    adv(); mem_done = 1'b1; #1;
    chk("R7 st T7", 7'd0, 8'd0, A_NO, M_WR, 3'd7, 1'b1);
  endtask

  task automatic t_br(input logic con);
    fetch(5'd8, 0);
    adv(); #1; chk("R8 br T3", S_RC, L_CON, A_NO, 8'h00, 3'd3, 1'b1);
    adv(); con_flag = con; #1;
    if (con) chk("R8 br taken", S_RB, L_PC, A_NO, 8'h00, 3'd4, 1'b1);
    else     chk("R8 br not taken", 7'd0, 8'd0, A_NO, 8'h00, 3'd4, 1'b1);
  endtask

  task automatic t_shr(input logic irzero, input int shifts);
    fetch(5'd26, 0);
    adv(); #1; chk("R9 shr T3", 7'd0, 8'd0, A_NO, M_NIR, 3'd3, 1'b1);
    adv(); n_is_zero = irzero; #1;
    if (irzero) chk("R9 shr T4 rc", S_RC, 8'd0, A_NO, M_NBUS, 3'd4, 1'b1);
    else        chk("R9 shr T4 ir", 7'd0, 8'd0, A_NO, 8'h00, 3'd4, 1'b1);
    adv(); n_is_zero = 1'b0; #1; chk("R9 shr T5", S_RB, L_C, A_PAS, 8'h00, 3'd5, 1'b1);
    for (int i = 0; i < shifts; i++) begin
      adv(); n_is_zero = 1'b0; #1;
      chk("R9 shr loop", 7'd0, 8'd0, A_NO, M_SHR | M_NDEC, 3'd6, 1'b1);
    end
    adv(); n_is_zero = 1'b1; #1; chk("R9 shr exit", 7'd0, 8'd0, A_NO, 8'h00, 3'd6, 1'b1);
    adv(); #1; chk("R9 shr T7", S_C, L_RA, A_NO, 8'h00, 3'd7, 1'b1);
  endtask

  task automatic t_nop();
    fetch(5'd0, 0);
    adv(); #1; chk("R10 nop T3", 7'd0, 8'd0, A_NO, 8'h00, 3'd3, 1'b1);
  endtask

  task automatic t_stop();
    fetch(5'd31, 0);
    adv(); #1; chk("R10 stop T3", 7'd0, 8'd0, A_NO, 8'h00, 3'd3, 1'b1);
    for (int i = 0; i < 3; i++) begin
      adv(); #1; chk("R10 halted idle", 7'd0, 8'd0, A_NO, 8'h00, 3'd0, 1'b0);
    end
  endtask

  task automatic do_start();
    adv(); start = 1'b1; #1;
    chk("R10 start cycle", 7'd0, 8'd0, A_NO, 8'h00, 3'd0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; ir_opcode = '0; rb_is_zero = 1'b0;
    con_flag = 1'b0; n_is_zero = 1'b0; mem_done = 1'b0;
    adv(); adv(); #1;
    chk("R1 reset", 7'd0, 8'd0, A_NO, 8'h00, 3'd0, 1'b0);
    adv(); rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      adv(); #1; chk("R3 idle no run", 7'd0, 8'd0, A_NO, 8'h00, 3'd0, 1'b0);
    end
    do_start();
    t_add();
    t_addi();
    t_ld(1'b1, 2);
    t_ld(1'b0, 0);
    t_st(2);
    t_br(1'b1);
    t_br(1'b0);
    t_shr(1'b1, 3);
    t_shr(1'b0, 0);
    t_nop();
    t_stop();
    do_start();
    t_nop();
    adv(); #1; chk("R11 back to T0", S_PC, L_MA | L_C, A_INC, 8'h00, 3'd0, 1'b1);
    adv(); mem_done = 1'b0; #1;
    chk("R4 T1 stall before reset", 7'd0, 8'd0, A_NO, M_RD, 3'd1, 1'b1);
    rst_n = 1'b0; #1;
    chk("R1 async reset mid-run", 7'd0, 8'd0, A_NO, 8'h00, 3'd0, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule